// File: doc/BRIEF.md
# Sector-Burst FIFO Data Mover

This block carries whole sectors between user FIFOs and an internal staging buffer. A sector is 512 bytes, and the block moves it as a burst of 32 back-to-back beats on a 128-bit bus. In the outbound direction it drains the user's transmit FIFO into the buffer. In the inbound direction it fills the user's receive FIFO from the buffer. Before each burst the block looks at the relevant FIFO counter and at a buffer-ready flag. It starts the burst only when one full sector can move without stalling.

A command is a one-cycle start pulse carrying a direction and a sector count. The block stays busy and repeats the check-then-burst cycle until the requested number of sectors has moved. It then pulses done and returns to idle. Both the FIFO and the buffer return read data one cycle after the read enable. The block forwards that data with the enable delayed by one cycle, so each beat is written in the order it was read.

The FIFO counters may be narrower than 16 bits. The block widens them to 16 bits internally. The transmit counter is padded with zeros and the receive counter with ones, so a narrow counter is judged the same way as a full-width one.

Top module: `sector_burst_mover`

## Requirements
- R1: After reset, busy, done, tx_rd_en, rx_wr_en, buf_rd_en and buf_wr_en are all 0.
- R2: With dir=0, a burst begins only while buf_ready is 1 and bits 15:5 of the transmit count are not all zero. The transmit count is zero-extended to 16 bits for this test.
- R3: Every burst holds its read enable high for exactly 32 consecutive cycles. The read enable is tx_rd_en when dir=0 and buf_rd_en when dir=1.
- R4: With dir=0, buf_wr_en is high in the cycle after each tx_rd_en cycle, and buf_wr_data equals tx_rd_data in that cycle. Beat order is preserved.
- R5: With dir=1, a burst begins only while buf_ready is 1 and bits 15:6 of the receive count are not all ones. The receive count is one-extended to 16 bits for this test.
- R6: With dir=1, rx_wr_en is high in the cycle after each buf_rd_en cycle, and rx_wr_data equals buf_rd_data in that cycle. Beat order is preserved.
- R7: A command of N>0 sectors produces exactly 32*N read beats and 32*N write beats. It then raises done for one cycle. busy is 0 in the cycle after done.
- R8: A start with a sector count of 0 raises done in the cycle after start is sampled. No enable is raised, and busy is 0 the cycle after done.
- R9: A start pulse that arrives while busy is 1 is ignored. It does not change the direction or the remaining count.
- R10: The direction code is fixed: dir=0 moves data from the transmit FIFO into the buffer, and dir=1 moves data from the buffer into the receive FIFO. The two read enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command pulse, accepted only when idle |
| dir | input | 1 | 0: transmit FIFO to buffer, 1: buffer to receive FIFO |
| sectors | input | LEN_W | Number of 512-byte sectors to move |
| busy | output | 1 | High from command acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| tx_rd_cnt | input | TX_CNT_W | Occupancy count of the transmit FIFO |
| tx_rd_en | output | 1 | Transmit FIFO read enable |
| tx_rd_data | input | DATA_W | Transmit FIFO data, valid one cycle after tx_rd_en |
| rx_wr_cnt | input | RX_CNT_W | Write-side count of the receive FIFO |
| rx_wr_en | output | 1 | Receive FIFO write enable |
| rx_wr_data | output | DATA_W | Receive FIFO write data |
| buf_ready | input | 1 | Buffer can accept a sector (dir=0) or holds a sector (dir=1) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | DATA_W | Buffer write data |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_data | input | DATA_W | Buffer data, valid one cycle after buf_rd_en |

## Verification
The assertions rely on three things about the inputs. FIFO and buffer data arrive exactly one cycle after their enable. The selected FIFO holds enough data, or space, for a whole burst once the gate has opened. buf_ready does not need to stay high during a burst.

The bench's FIFO and buffer models return data one cycle after each enable beat. The bench keeps the counters constant while bursts run. It moves the counters across the gate thresholds only while the block waits in its check step.

// File: rtl/smv_pkg.sv
package smv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BURST = 2'd2,
        ST_FIN   = 2'd3
    } smv_state_e;

endpackage

// File: rtl/smv_gate.sv
module smv_gate #(
    parameter int CNT_W    = 16,
    parameter int TX_CNT_W = 16,
    parameter int RX_CNT_W = 16,
    parameter int BEAT_LG  = 5
) (
    input  logic [TX_CNT_W-1:0] tx_cnt,
    input  logic [RX_CNT_W-1:0] rx_cnt,
    output logic                tx_ok,
    output logic                rx_ok
);
    logic [CNT_W-1:0] tx_full;
    logic [CNT_W-1:0] rx_full;

    // Transmit counter: narrow counters are zero-extended.
    generate
        if (TX_CNT_W < CNT_W) begin : g_tx_pad
            assign tx_full = {{(CNT_W-TX_CNT_W){1'b0}}, tx_cnt};
        end else begin : g_tx_full
            assign tx_full = tx_cnt[CNT_W-1:0];
        end
    endgenerate

    // Receive counter: narrow counters are one-extended.
    generate
        if (RX_CNT_W < CNT_W) begin : g_rx_pad
            assign rx_full = {{(CNT_W-RX_CNT_W){1'b1}}, rx_cnt};
        end else begin : g_rx_full
            assign rx_full = rx_cnt[CNT_W-1:0];
        end
    endgenerate

    // A whole burst is present in the transmit FIFO.
    assign tx_ok = |tx_full[CNT_W-1:BEAT_LG];
    // The receive FIFO is not in its top region.
    assign rx_ok = ~&rx_full[CNT_W-1:BEAT_LG+1];

endmodule

// File: rtl/smv_dstage.sv
module smv_dstage #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_en,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_en,
    output logic [DATA_W-1:0] dst_data
);
    logic en_d, en_q;

    always_comb begin
        en_d = src_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    // Source data is valid one cycle after its enable, aligned with en_q.
    assign dst_en   = en_q;
    assign dst_data = src_data;

endmodule

// File: rtl/smv_ctrl.sv
module smv_ctrl
    import smv_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int BEAT_LG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir,
    input  logic [LEN_W-1:0] sectors,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             buf_ready,
    output logic             busy,
    output logic             done,
    output logic             tx_en,
    output logic             brd_en
);
    localparam int                 BEATS     = 1 << BEAT_LG;
    localparam logic [BEAT_LG-1:0] LAST_BEAT = BEAT_LG'(BEATS - 1);
    localparam int                 RUN_W     = BEAT_LG + 2;

    typedef struct packed {
        smv_state_e         st;
        logic               dir;
        logic [LEN_W-1:0]   rem;
        logic [BEAT_LG-1:0] beat;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.dir  = dir;
                    nxt_d.rem  = sectors;
                    nxt_d.beat = '0;
                    nxt_d.st   = (sectors == '0) ? ST_FIN : ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (buf_ready && (cur_q.dir ? rx_ok : tx_ok)) begin
                    nxt_d.beat = '0;
                    nxt_d.st   = ST_BURST;
                end
            end
            ST_BURST: begin
                nxt_d.beat = cur_q.beat + 1'b1;
                if (cur_q.beat == LAST_BEAT) begin
                    nxt_d.rem = cur_q.rem - LEN_W'(1);
                    nxt_d.st  = (cur_q.rem == LEN_W'(1)) ? ST_FIN : ST_CHECK;
                end
            end
            ST_FIN: begin
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.dir  <= 1'b0;
            cur_q.rem  <= '0;
            cur_q.beat <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = (cur_q.st != ST_IDLE);
    assign done   = (cur_q.st == ST_FIN);
    assign tx_en  = (cur_q.st == ST_BURST) && !cur_q.dir;
    assign brd_en = (cur_q.st == ST_BURST) &&  cur_q.dir;

    // Checker state: length of the current enable run.
    logic [RUN_W-1:0] tx_run_q, brd_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_run_q  <= '0;
            brd_run_q <= '0;
        end else begin
            tx_run_q  <= tx_en  ? tx_run_q  + 1'b1 : '0;
            brd_run_q <= brd_en ? brd_run_q + 1'b1 : '0;
        end
    end

    a_r3_tx_run_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_run_q != '0) |-> tx_run_q == RUN_W'(BEATS));
    a_r3_brd_run_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!brd_en && brd_run_q != '0) |-> brd_run_q == RUN_W'(BEATS));
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sectors == '0) |=> (done && !tx_en && !brd_en));
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: rtl/sector_burst_mover.sv
module sector_burst_mover #(
    parameter int DATA_W   = 128,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int TX_CNT_W = 16,
    parameter int RX_CNT_W = 16,
    parameter int BEAT_LG  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dir,
    input  logic [LEN_W-1:0]    sectors,
    output logic                busy,
    output logic                done,
    input  logic [TX_CNT_W-1:0] tx_rd_cnt,
    output logic                tx_rd_en,
    input  logic [DATA_W-1:0]   tx_rd_data,
    input  logic [RX_CNT_W-1:0] rx_wr_cnt,
    output logic                rx_wr_en,
    output logic [DATA_W-1:0]   rx_wr_data,
    input  logic                buf_ready,
    output logic                buf_wr_en,
    output logic [DATA_W-1:0]   buf_wr_data,
    output logic                buf_rd_en,
    input  logic [DATA_W-1:0]   buf_rd_data
);
    logic tx_ok, rx_ok;

    smv_gate #(
        .CNT_W   (CNT_W),
        .TX_CNT_W(TX_CNT_W),
        .RX_CNT_W(RX_CNT_W),
        .BEAT_LG (BEAT_LG)
    ) u_gate (
        .tx_cnt(tx_rd_cnt),
        .rx_cnt(rx_wr_cnt),
        .tx_ok (tx_ok),
        .rx_ok (rx_ok)
    );

    smv_ctrl #(
        .LEN_W  (LEN_W),
        .BEAT_LG(BEAT_LG)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dir      (dir),
        .sectors  (sectors),
        .tx_ok    (tx_ok),
        .rx_ok    (rx_ok),
        .buf_ready(buf_ready),
        .busy     (busy),
        .done     (done),
        .tx_en    (tx_rd_en),
        .brd_en   (buf_rd_en)
    );

    smv_dstage #(.DATA_W(DATA_W)) u_wr_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (tx_rd_en),
        .src_data(tx_rd_data),
        .dst_en  (buf_wr_en),
        .dst_data(buf_wr_data)
    );

    smv_dstage #(.DATA_W(DATA_W)) u_rd_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (buf_rd_en),
        .src_data(buf_rd_data),
        .dst_en  (rx_wr_en),
        .dst_data(rx_wr_data)
    );

    a_r2_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rd_en) |-> $past(tx_ok && buf_ready));
    a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd_en) |-> $past(rx_ok && buf_ready));
    a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_rd_en && buf_rd_en));
    a_r4_wr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd_en |=> buf_wr_en);
    a_r6_rx_follows: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> rx_wr_en);

endmodule

// File: tb/sector_burst_mover_bench.sv
module sector_burst_mover_bench;
    localparam int DW = 128;
    localparam int LW = 8;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir = 1'b0;
    logic [LW-1:0] sectors = '0;
    logic          busy, done;
    logic [CW-1:0] tx_rd_cnt = '0;
    logic          tx_rd_en;
    logic [DW-1:0] tx_rd_data = '0;
    logic [CW-1:0] rx_wr_cnt = '0;
    logic          rx_wr_en;
    logic [DW-1:0] rx_wr_data;
    logic          buf_ready = 1'b0;
    logic          buf_wr_en;
    logic [DW-1:0] buf_wr_data;
    logic          buf_rd_en;
    logic [DW-1:0] buf_rd_data = '0;

    always #5 clk = ~clk;

    sector_burst_mover #(
        .DATA_W(DW), .LEN_W(LW), .CNT_W(16),
        .TX_CNT_W(CW), .RX_CNT_W(CW), .BEAT_LG(5)
    ) u_sector_burst_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .sectors(sectors),
        .busy(busy), .done(done),
        .tx_rd_cnt(tx_rd_cnt), .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .rx_wr_cnt(rx_wr_cnt), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .buf_ready(buf_ready), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
        .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data)
    );

    int checks = 0;
    int failures = 0;

    // Source models: data one cycle after each enable beat.
    int tx_seq = 0;
    int br_seq = 0;
    always @(posedge clk) begin
        if (tx_rd_en) begin
            tx_rd_data <= {4{32'(tx_seq)}};
            tx_seq <= tx_seq + 1;
        end
        if (buf_rd_en) begin
            buf_rd_data <= {4{32'h5A000000 ^ 32'(br_seq)}};
            br_seq <= br_seq + 1;
        end
    end

    // Monitors.
    int tx_en_n = 0, br_en_n = 0, bw_n = 0, rw_n = 0, done_n = 0;
    int data_err = 0, run_err = 0, both_err = 0;
    int tx_run = 0, br_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_rd_en) tx_en_n++;
            if (buf_rd_en) br_en_n++;
            if (done) done_n++;
            if (tx_rd_en && buf_rd_en) both_err++;
            if (buf_wr_en) begin
                if (buf_wr_data !== {4{32'(bw_n)}}) data_err++;
                bw_n++;
            end
            if (rx_wr_en) begin
                if (rx_wr_data !== {4{32'h5A000000 ^ 32'(rw_n)}}) data_err++;
                rw_n++;
            end
            if (tx_rd_en) tx_run++;
            else begin
                if (tx_run != 0 && tx_run != 32) run_err++;
                tx_run = 0;
            end
            if (buf_rd_en) br_run++;
            else begin
                if (br_run != 0 && br_run != 32) run_err++;
                br_run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic d, input int n);
        @(negedge clk);
        dir = d; sectors = LW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int i = 0; i < 4000 && done_n == d0; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Full command with gates open; checks totals against 32*N.
    task automatic run_cmd(input logic d, input int n);
        int t0, b0, w0, r0, dn0, de0, re0;
        t0 = tx_en_n; b0 = br_en_n; w0 = bw_n; r0 = rw_n;
        dn0 = done_n; de0 = data_err; re0 = run_err;
        pulse_start(d, n);
        wait_done(dn0);
        chk(tx_en_n - t0 == (d ? 0 : 32*n), "R7 tx read beats", tx_en_n - t0, d ? 0 : 32*n);
        chk(bw_n - w0 == (d ? 0 : 32*n), "R4 buffer write beats", bw_n - w0, d ? 0 : 32*n);
        chk(br_en_n - b0 == (d ? 32*n : 0), "R10 buffer read beats", br_en_n - b0, d ? 32*n : 0);
        chk(rw_n - r0 == (d ? 32*n : 0), "R6 rx write beats", rw_n - r0, d ? 32*n : 0);
        chk(done_n - dn0 == 1, "R7 done pulses", done_n - dn0, 1);
        chk(data_err == de0, "R4/R6 data order errors", data_err - de0, 0);
        chk(run_err == re0, "R3 burst run length errors", run_err - re0, 0);
        chk(busy == 1'b0, "R7 busy after done", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t0, b0, dn0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done in reset", int'({busy, done}), 0);
        chk(!tx_rd_en && !buf_rd_en && !buf_wr_en && !rx_wr_en,
            "R1 enables in reset", int'({tx_rd_en, buf_rd_en, buf_wr_en, rx_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);

        // R2: count 31 below threshold (zero padding keeps bits 15:5 zero)
        tx_rd_cnt = 10'd31; buf_ready = 1'b1; rx_wr_cnt = '0;
        t0 = tx_en_n; dn0 = done_n;
        pulse_start(1'b0, 1);
        repeat (40) @(negedge clk);
        chk(tx_en_n == t0, "R2 stall at count 31", tx_en_n - t0, 0);
        chk(busy == 1'b1, "R2 busy while waiting", int'(busy), 1);
        // R2: count full (bits set) but buffer not ready
        buf_ready = 1'b0; tx_rd_cnt = 10'h3FF;
        repeat (40) @(negedge clk);
        chk(tx_en_n == t0, "R2 stall without buf_ready", tx_en_n - t0, 0);
        tx_rd_cnt = 10'd32; buf_ready = 1'b1;
        wait_done(dn0);
        chk(tx_en_n - t0 == 32, "R2 burst at count 32", tx_en_n - t0, 32);

        // R5: receive count 960 -> bits 9:6 all ones, ones-padded above
        rx_wr_cnt = 10'd960; b0 = br_en_n; dn0 = done_n;
        pulse_start(1'b1, 1);
        repeat (40) @(negedge clk);
        chk(br_en_n == b0, "R5 stall at rx count 960", br_en_n - b0, 0);
        rx_wr_cnt = 10'h3FF;
        repeat (20) @(negedge clk);
        chk(br_en_n == b0, "R5 stall at rx count 1023", br_en_n - b0, 0);
        rx_wr_cnt = 10'd959; buf_ready = 1'b0;
        repeat (20) @(negedge clk);
        chk(br_en_n == b0, "R5 stall without buf_ready", br_en_n - b0, 0);
        buf_ready = 1'b1;
        wait_done(dn0);
        chk(br_en_n - b0 == 32, "R5 burst at rx count 959", br_en_n - b0, 32);

        // R8: zero count
        t0 = tx_en_n; b0 = br_en_n; dn0 = done_n;
        @(negedge clk);
        dir = 1'b0; sectors = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R8 done after zero-count start", int'(done), 1);
        @(negedge clk);
        chk(!done && !busy, "R8 idle after zero-count done", int'({done, busy}), 0);
        repeat (3) @(negedge clk);
        chk(tx_en_n == t0 && br_en_n == b0, "R8 no enable for zero count",
            tx_en_n - t0 + br_en_n - b0, 0);

        // R9: start while busy is ignored
        tx_rd_cnt = 10'd64; rx_wr_cnt = '0;
        t0 = tx_en_n; b0 = br_en_n; dn0 = done_n;
        pulse_start(1'b0, 2);
        repeat (10) @(negedge clk);
        pulse_start(1'b1, 5);
        wait_done(dn0);
        chk(tx_en_n - t0 == 64, "R9 tx beats unaffected", tx_en_n - t0, 64);
        chk(br_en_n == b0, "R9 no buffer reads", br_en_n - b0, 0);
        chk(done_n - dn0 == 1, "R9 single done", done_n - dn0, 1);

        // Sweep directions and lengths (R3 R4 R6 R7 R10)
        for (int d = 0; d < 2; d++) begin
            for (int n = 1; n <= 4; n++) begin
                run_cmd(d[0], n);
            end
        end
        chk(both_err == 0, "R10 enables exclusive", both_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule